// File: doc/BRIEF.md
# Round-Robin Reference Clock Selector

The selector decides which of several reference clock inputs feeds a PLL. It only produces the choice. Detecting a lost clock and building a glitch-free clock multiplexer are left to the logic around it. A mode input selects one of two kinds of behaviour. A manual code pins the selection to one fixed input. The automatic code makes the block rotate through the enabled inputs, moving one step each time a switch event arrives.

Switch events arrive as single-cycle synchronous pulses. A per-input enable vector marks the inputs that the rotation may visit. The PLL lock indication matters only at the moment automatic mode is entered. A locked PLL keeps its present reference. An unlocked PLL moves to the first enabled input, searching forward from the present one. The block reports the selection both as a binary index and as a one-hot vector. It also gives a one-cycle pulse whenever the selection changes, and a flag when automatic mode has no input to choose from.

Top module: `rrsel_core`

## Requirements
- R1: After reset the selection index is 0, the one-hot select is 3'b001, and the switched pulse and the error flag are both low.
- R2: The mode is a 3-bit code. Codes 0, 1 and 2 are manual and force the selection to input 0, 1 or 2 at the next clock edge, whatever the enable bits are.
- R3: In a manual mode a switch pulse has no effect, and the selection remains the forced input.
- R4: Codes 3, 5, 6 and 7 are reserved. Under a reserved code the selection holds and switch pulses are ignored.
- R5: Code 4 is automatic mode. It counts as entered on the first cycle with code 4 after any other code, or after reset. If the lock input is high in that cycle, the selection is unchanged.
- R6: If the lock input is low on entry to automatic mode, the selection moves to the first enabled input found by searching cyclically from the current input, the current input included. A switch pulse in the entry cycle is ignored.
- R7: In automatic mode after the entry cycle, a switch pulse moves the selection at the next edge to the next enabled input after the current one, in the cyclic order 0, 1, 2, 0. Disabled inputs are skipped.
- R8: With exactly one input enabled, a switch pulse selects that input, so repeated pulses leave the selection unchanged.
- R9: In automatic mode with no input enabled, the selection holds. The error flag is high in the cycle after each such cycle and low after any other cycle.
- R10: In automatic mode after the entry cycle, with no switch pulse, the selection holds.
- R11: The switched output is high for exactly the cycle that follows a clock edge at which the selection index changed.
- R12: The one-hot select always has exactly one bit set, at the position of the selection index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Mode code: 0..2 manual, 4 automatic, others reserved |
| enable_i | input | 3 | Per-input eligibility for automatic rotation |
| lock_i | input | 1 | PLL lock indication |
| switch_i | input | 1 | Single-cycle switch event |
| sel_idx_o | output | 2 | Active input index |
| sel_onehot_o | output | 3 | Active input, one-hot |
| switched_o | output | 1 | One-cycle pulse after a selection change |
| no_src_err_o | output | 1 | Automatic mode found no enabled input |

## Verification
The bench uses the default parameters: three inputs, a 3-bit mode code and automatic code 4. With three inputs, every one of the eight enable patterns can be combined with every starting input. That covers each wrap from input 2 back to input 0, every way a skip can occur, and the single-input and empty cases. A long pseudo-random run also changes mode, lock and enables in the middle of a rotation. Each such change exercises re-entry into automatic mode from a manual or reserved code, both with the lock input high and with it low.

// File: rtl/rrsel_pkg.sv
package rrsel_pkg;

    // What the selector does with its selection in the coming edge.
    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_FORCE = 3'd1,
        ACT_KEEP  = 3'd2,
        ACT_SEEK  = 3'd3,
        ACT_STEP  = 3'd4,
        ACT_NOSRC = 3'd5
    } sel_act_e;

endpackage

// File: rtl/rrsel_search.sv
// Cyclic search for the first enabled input starting at (or just after)
// a given position.
module rrsel_search #(
    parameter int unsigned N_IN      = 3,
    parameter int unsigned IDX_W     = (N_IN > 1) ? $clog2(N_IN) : 1,
    parameter bit          INCLUSIVE = 1'b1
) (
    input  logic [IDX_W-1:0] start_i,
    input  logic [N_IN-1:0]  enable_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam int unsigned SUM_W = IDX_W + 1;

    logic [IDX_W-1:0] cand [N_IN];
    logic [N_IN-1:0]  hit;

    for (genvar k = 0; k < N_IN; k++) begin : g_cand
        localparam int unsigned OFF = INCLUSIVE ? k : k + 1;
        logic [SUM_W-1:0] sum;
        always_comb begin
            sum = {1'b0, start_i} + SUM_W'(OFF);
            if (sum >= SUM_W'(N_IN)) begin
                sum = sum - SUM_W'(N_IN);
            end
        end
        assign cand[k] = sum[IDX_W-1:0];
        assign hit[k]  = enable_i[cand[k]];
    end

    always_comb begin
        found_o = 1'b0;
        idx_o   = start_i;
        for (int k = N_IN - 1; k >= 0; k--) begin
            if (hit[k]) begin
                found_o = 1'b1;
                idx_o   = cand[k];
            end
        end
    end
endmodule

// File: rtl/rrsel_mode_decode.sv
// Classifies the mode code and the events of this cycle into one action.
module rrsel_mode_decode
    import rrsel_pkg::*;
#(
    parameter int unsigned N_IN      = 3,
    parameter int unsigned MODE_W    = 3,
    parameter int unsigned AUTO_CODE = 4
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic              auto_q_i,
    input  logic              lock_i,
    input  logic              switch_i,
    input  logic              any_en_i,
    output logic              is_auto_o,
    output sel_act_e          act_o
);
    localparam logic [MODE_W-1:0] LAST_MANUAL = MODE_W'(N_IN - 1);
    localparam logic [MODE_W-1:0] AUTO_VAL    = MODE_W'(AUTO_CODE);

    always_comb begin
        is_auto_o = (mode_i == AUTO_VAL);
        act_o     = ACT_HOLD;
        if (mode_i <= LAST_MANUAL) begin
            act_o = ACT_FORCE;
        end else if (is_auto_o) begin
            if (!any_en_i) begin
                act_o = ACT_NOSRC;
            end else if (!auto_q_i) begin
                act_o = lock_i ? ACT_KEEP : ACT_SEEK;
            end else if (switch_i) begin
                act_o = ACT_STEP;
            end
        end
    end
endmodule

// File: rtl/rrsel_onehot.sv
// Binary index to one-hot select.
module rrsel_onehot #(
    parameter int unsigned N_IN  = 3,
    parameter int unsigned IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [N_IN-1:0]  onehot_o
);
    for (genvar i = 0; i < N_IN; i++) begin : g_bit
        assign onehot_o[i] = (idx_i == IDX_W'(i));
    end
endmodule

// File: rtl/rrsel_core.sv
module rrsel_core
    import rrsel_pkg::*;
#(
    parameter int unsigned N_IN      = 3,
    parameter int unsigned MODE_W    = 3,
    parameter int unsigned AUTO_CODE = 4,
    parameter int unsigned RESET_SEL = 0,
    localparam int unsigned IDX_W    = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [N_IN-1:0]   enable_i,
    input  logic              lock_i,
    input  logic              switch_i,
    output logic [IDX_W-1:0]  sel_idx_o,
    output logic [N_IN-1:0]   sel_onehot_o,
    output logic              switched_o,
    output logic              no_src_err_o
);
    typedef struct packed {
        logic [IDX_W-1:0] sel;
        logic             auto_on;
        logic             switched;
        logic             err;
    } sel_state_t;

    localparam sel_state_t RESET_STATE = '{
        sel:      IDX_W'(RESET_SEL),
        auto_on:  1'b0,
        switched: 1'b0,
        err:      1'b0
    };

    sel_state_t state_d, state_q;

    logic             is_auto;
    sel_act_e         act;
    logic             seek_found, step_found;
    logic [IDX_W-1:0] seek_idx, step_idx;
    logic             any_en;

    assign any_en = |enable_i;

    rrsel_mode_decode #(
        .N_IN      (N_IN),
        .MODE_W    (MODE_W),
        .AUTO_CODE (AUTO_CODE)
    ) u_decode (
        .mode_i    (mode_i),
        .auto_q_i  (state_q.auto_on),
        .lock_i    (lock_i),
        .switch_i  (switch_i),
        .any_en_i  (any_en),
        .is_auto_o (is_auto),
        .act_o     (act)
    );

    // Entry search: current input counts as a candidate.
    rrsel_search #(
        .N_IN      (N_IN),
        .IDX_W     (IDX_W),
        .INCLUSIVE (1'b1)
    ) u_seek (
        .start_i  (state_q.sel),
        .enable_i (enable_i),
        .found_o  (seek_found),
        .idx_o    (seek_idx)
    );

    // Rotation search: starts one past the current input.
    rrsel_search #(
        .N_IN      (N_IN),
        .IDX_W     (IDX_W),
        .INCLUSIVE (1'b0)
    ) u_step (
        .start_i  (state_q.sel),
        .enable_i (enable_i),
        .found_o  (step_found),
        .idx_o    (step_idx)
    );

    always_comb begin
        state_d         = state_q;
        state_d.auto_on = is_auto;
        state_d.err     = (act == ACT_NOSRC);
        unique case (act)
            ACT_FORCE: state_d.sel = IDX_W'(mode_i);
            ACT_SEEK:  if (seek_found) state_d.sel = seek_idx;
            ACT_STEP:  if (step_found) state_d.sel = step_idx;
            default:   state_d.sel = state_q.sel;
        endcase
        state_d.switched = (state_d.sel != state_q.sel);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= RESET_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    rrsel_onehot #(
        .N_IN  (N_IN),
        .IDX_W (IDX_W)
    ) u_onehot (
        .idx_i    (state_q.sel),
        .onehot_o (sel_onehot_o)
    );

    assign sel_idx_o    = state_q.sel;
    assign switched_o   = state_q.switched;
    assign no_src_err_o = state_q.err;
endmodule

// File: rtl/rrsel_checker.sv
module rrsel_checker #(
    parameter int unsigned N_IN      = 3,
    parameter int unsigned MODE_W    = 3,
    parameter int unsigned AUTO_CODE = 4,
    parameter int unsigned IDX_W     = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [MODE_W-1:0] mode_i,
    input logic [N_IN-1:0]   enable_i,
    input logic              lock_i,
    input logic              switch_i,
    input logic [IDX_W-1:0]  sel_idx_o,
    input logic [N_IN-1:0]   sel_onehot_o,
    input logic              switched_o,
    input logic              no_src_err_o
);
    localparam logic [MODE_W-1:0] LAST_MANUAL = MODE_W'(N_IN - 1);
    localparam logic [MODE_W-1:0] AUTO_VAL    = MODE_W'(AUTO_CODE);

    logic prev_auto;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_auto <= 1'b0;
        else         prev_auto <= (mode_i == AUTO_VAL);
    end

    p_manual_force_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i <= LAST_MANUAL) |=> (MODE_W'(sel_idx_o) == $past(mode_i)));

    p_reserved_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i > LAST_MANUAL && mode_i != AUTO_VAL) |=> $stable(sel_idx_o));

    p_entry_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == AUTO_VAL && !prev_auto && lock_i) |=> $stable(sel_idx_o));

    p_step_enabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == AUTO_VAL && prev_auto && switch_i && enable_i != '0)
        |=> ((($past(enable_i) >> sel_idx_o) & N_IN'(1)) != '0));

    p_nosrc_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == AUTO_VAL && enable_i == '0) |=> (no_src_err_o && $stable(sel_idx_o)));

    p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == AUTO_VAL && prev_auto && !switch_i) |=> $stable(sel_idx_o));

    p_switched_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (switched_o == (sel_idx_o != $past(sel_idx_o))));

    p_onehot_match_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(sel_onehot_o) == 1) && sel_onehot_o[sel_idx_o]);
endmodule

bind rrsel_core rrsel_checker #(
    .N_IN      (N_IN),
    .MODE_W    (MODE_W),
    .AUTO_CODE (AUTO_CODE),
    .IDX_W     (IDX_W)
) u_rrsel_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_i),
    .enable_i     (enable_i),
    .lock_i       (lock_i),
    .switch_i     (switch_i),
    .sel_idx_o    (sel_idx_o),
    .sel_onehot_o (sel_onehot_o),
    .switched_o   (switched_o),
    .no_src_err_o (no_src_err_o)
);

// File: tb/test_rrsel_core.sv
`timescale 1ns/1ps
module test_rrsel_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [2:0] en = 3'b111;
    logic       lock = 1'b0;
    logic       sw = 1'b0;
    logic [1:0] sel_idx;
    logic [2:0] sel_oh;
    logic       switched;
    logic       err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural model state
    int  m_sel  = 0;
    bit  m_auto = 0;
    bit  m_sw   = 0;
    bit  m_err  = 0;

    always #10 clk = ~clk;

    rrsel_core i_rrsel_core (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .mode_i       (mode),
        .enable_i     (en),
        .lock_i       (lock),
        .switch_i     (sw),
        .sel_idx_o    (sel_idx),
        .sel_onehot_o (sel_oh),
        .switched_o   (switched),
        .no_src_err_o (err)
    );

    function automatic int find_en(int start, int ofs, logic [2:0] e);
        for (int k = 0; k < 3; k++) begin
            int c = (start + k + ofs) % 3;
            if (e[c]) return c;
        end
        return start;
    endfunction

    task automatic compare(input string tag);
        logic [2:0] exp_oh = 3'b001 << m_sel;
        checks++;
        if (sel_idx !== 2'(m_sel) || sel_oh !== exp_oh ||
            switched !== m_sw || err !== m_err) begin
            errors++;
            $display("FAIL %s: got idx=%0d oh=%b sw=%b err=%b, expected idx=%0d oh=%b sw=%b err=%b",
                     tag, sel_idx, sel_oh, switched, err, m_sel, exp_oh, m_sw, m_err);
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, check after the next edge.
    task automatic step(input logic [2:0] md, input logic [2:0] e,
                        input logic lk, input logic s, input string tag);
        int  nsel = m_sel;
        bit  is_auto = (md == 3'd4);
        mode = md; en = e; lock = lk; sw = s;
        if (md <= 3'd2) nsel = int'(md);
        else if (is_auto && e != 3'b000) begin
            if (!m_auto) begin
                if (!lk) nsel = find_en(m_sel, 0, e);
            end else if (s) begin
                nsel = find_en(m_sel, 1, e);
            end
        end
        m_err  = is_auto && (e == 3'b000);
        m_sw   = (nsel != m_sel);
        m_auto = is_auto;
        m_sel  = nsel;
        @(posedge clk);
        @(negedge clk);
        sw = 1'b0;
        compare(tag);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
                finish_run();
            end
        end
    end

    initial begin
        int unsigned lcg = 32'h1234_5678;
        repeat (3) @(negedge clk);
        compare("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // R2 manual forcing, enables irrelevant
        step(3'd2, 3'b000, 1'b0, 1'b0, "R2 force 2");
        step(3'd1, 3'b001, 1'b0, 1'b0, "R2 force 1");
        step(3'd0, 3'b110, 1'b1, 1'b0, "R2 force 0");
        // R3 switch ignored in manual
        step(3'd0, 3'b111, 1'b1, 1'b1, "R3 switch in manual");
        step(3'd2, 3'b111, 1'b1, 1'b0, "R2 force 2 again");
        step(3'd2, 3'b111, 1'b1, 1'b1, "R3 switch in manual 2");
        // R4 reserved codes
        step(3'd3, 3'b111, 1'b0, 1'b1, "R4 reserved 3");
        step(3'd7, 3'b111, 1'b0, 1'b1, "R4 reserved 7");
        step(3'd5, 3'b011, 1'b0, 1'b0, "R4 reserved 5");
        // R5 entry with lock keeps input 1, even with a switch pulse
        step(3'd1, 3'b111, 1'b1, 1'b0, "R2 force 1");
        step(3'd4, 3'b111, 1'b1, 1'b1, "R5 entry locked");
        step(3'd4, 3'b111, 1'b1, 1'b0, "R10 idle hold");
        // R7 rotation 1->2->0->1
        step(3'd4, 3'b111, 1'b1, 1'b1, "R7 step to 2");
        step(3'd4, 3'b111, 1'b0, 1'b0, "R11 pulse ends");
        step(3'd4, 3'b111, 1'b0, 1'b1, "R7 wrap to 0");
        step(3'd4, 3'b111, 1'b0, 1'b1, "R7 step to 1");
        // R7 skip: enables 0 and 2
        step(3'd4, 3'b101, 1'b0, 1'b1, "R7 skip to 2");
        step(3'd4, 3'b101, 1'b0, 1'b1, "R7 skip wrap to 0");
        step(3'd4, 3'b101, 1'b0, 1'b1, "R7 skip over 1");
        // R8 single enabled
        step(3'd4, 3'b010, 1'b0, 1'b1, "R8 move to only input");
        step(3'd4, 3'b010, 1'b0, 1'b1, "R8 stays put");
        // R9 none enabled
        step(3'd4, 3'b000, 1'b0, 1'b1, "R9 no source");
        step(3'd4, 3'b000, 1'b0, 1'b0, "R9 still no source");
        step(3'd4, 3'b100, 1'b0, 1'b0, "R9 flag clears");
        // R6 entry unlocked: at 2 with 2 disabled -> 0
        step(3'd2, 3'b011, 1'b0, 1'b0, "R2 force 2");
        step(3'd4, 3'b011, 1'b0, 1'b1, "R6 entry seek wraps");
        step(3'd1, 3'b011, 1'b0, 1'b0, "R2 force 1");
        step(3'd4, 3'b011, 1'b0, 1'b0, "R6 entry keeps enabled current");

        for (int i = 0; i < 400; i++) begin
            logic [2:0] md;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            md = (lcg[31:29] < 3'd5) ? 3'd4 : lcg[26:24];
            step(md, lcg[22:20], lcg[18], lcg[15] | lcg[12], "R7 random mix");
        end
        finish_run();
    end
endmodule